// File: doc/BRIEF.md
# Register Preload and Security Lock Controller

This block is the test and configuration access port of a small programmable logic device. A host sends commands over a valid/ready handshake. Each command carries an opcode, an address field and a data field. The commands can force single output registers high or low, program and verify a modelled configuration array, read and write a 64-bit user signature held as eight bytes, set a sticky security lock, and run a full erase. Every command except the idle opcode and the erase is answered one cycle after it is accepted, with a single-cycle response strobe, an error flag and read data. The erase answers when it has finished.

The security lock is one sticky bit. From the cycle after the lock command is accepted, configuration verify and register preload are refused. Configuration writes and all signature access keep working. The only way to clear the lock is the erase command. The erase walks the configuration array to zero one entry per cycle and holds off new commands while it runs. In normal operation the output registers load a parallel word from the device logic. A preload on the same clock edge overrides that load for the one register it names.

Top module: `lock_preload_ctrl`

## Requirements
- R1: While `rst_n` is low and after reset, `rsp_valid` is 0, `locked` is 0, `reg_q` is all zeros, `cmd_ready` is 1, and the configuration and signature stores read as zero.
- R2: A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both 1. Opcodes are: 0 idle, 1 preload, 2 configuration write, 3 configuration verify, 4 signature write, 5 signature read, 6 lock, 7 erase. Opcodes 1 to 6 produce `rsp_valid` high for exactly the one cycle after acceptance. Opcode 0 produces no response.
- R3: Preload (1) sets output register `cmd_addr` to `cmd_data[0]` and leaves the other registers unchanged. It takes priority over the parallel load for that one register on the same edge.
- R4: When `run_en` is 1, every register that is not being preloaded on that edge loads its bit of `run_d`. When `run_en` is 0 and no preload is accepted, `reg_q` holds.
- R5: Configuration write (2) stores `cmd_data` at `cmd_addr`. Verify (3) returns the stored byte on `rsp_data` with `rsp_err` 0 while unlocked.
- R6: Signature write (4) and read (5) address bytes 0 to 7 through `cmd_addr`. A read returns the byte with `rsp_err` 0 whether or not the block is locked.
- R7: Lock (6) sets `locked` on its acceptance edge and answers with `rsp_err` 0. The lock applies to a command accepted on the very next edge.
- R8: While locked, preload and verify are answered with `rsp_err` 1 and `rsp_data` 0, and `reg_q` is not changed by the preload. Configuration writes are still accepted without error.
- R9: A refused command changes no state. Refusals are: preload with index 8 or more, signature access with address 8 or more, and the locked cases in R8. Every refusal, and every response that is not a read, carries `rsp_data` 0.
- R10: Erase (7) drives `cmd_ready` low for 16 cycles, one per configuration entry. It then answers with `rsp_err` 0 and clears `locked`, and the whole configuration array reads back 0. The signature is kept. `locked` falls only at the end of an erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted (low during erase) |
| cmd_op | input | 3 | Opcode |
| cmd_addr | input | 4 | Entry, byte or register index |
| cmd_data | input | 8 | Write data; bit 0 is the preload value |
| rsp_valid | output | 1 | Single-cycle response strobe |
| rsp_err | output | 1 | Command refused |
| rsp_data | output | 8 | Read data, zero when not a read or refused |
| locked | output | 1 | Security lock state |
| run_en | input | 1 | Parallel load enable for the output registers |
| run_d | input | 8 | Parallel load word from the logic |
| reg_q | output | 8 | Output register state |

## Verification
The bench issues a verify and a preload back-to-back right after the lock. A design that applied the lock one cycle late would answer the first of these without error and would leak array contents. Signature reads while locked show up a lock that gates too much. A preload issued together with a parallel load catches a wrong priority, which either loses the preload or lets the parallel load overwrite it. Out-of-range indices, a command held during erase, and the state after erase catch a refusal that still writes, an erase that accepts commands early or skips entries, and an erase that wipes the signature or leaves the lock set.

// File: rtl/plk_pkg.sv
// Package: shared opcode encoding and field widths of the lock/preload controller.
// Assumes the host encodes opcodes in OP_W bits exactly as listed here.
package plk_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE    = 3'd0,
        OP_PRELOAD = 3'd1,
        OP_CFG_WR  = 3'd2,
        OP_CFG_VFY = 3'd3,
        OP_SIG_WR  = 3'd4,
        OP_SIG_RD  = 3'd5,
        OP_LOCK    = 3'd6,
        OP_ERASE   = 3'd7
    } plk_op_e;
endpackage

// File: rtl/plk_store.sv
// Module: plk_store - small register-file store with one write port and one
// combinational read port sharing an address. Used for both the configuration
// array and the user signature. Assumes a single writer; clears to zero on reset.
module plk_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Write port: clear all entries on reset, otherwise store on write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Read port: combinational lookup at the shared address.
    assign rdata = mem[addr];

    // R5/R10: a write lands in the addressed entry on the next cycle.
    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/plk_outreg.sv
// Module: plk_outreg - bank of output registers. Each bit loads the parallel
// word when run_en is high, unless a preload names that bit on the same edge,
// in which case the preload value wins. Assumes pl_idx < N when pl_we is high.
module plk_outreg #(
    parameter int N     = 8,
    localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic [N-1:0]  run_d,
    input  logic          pl_we,
    input  logic [IW-1:0] pl_idx,
    input  logic          pl_val,
    output logic [N-1:0]  q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // One output register: reset low, preload beats parallel load.
        always_ff @(posedge clk) begin
            if (!rst_n)                            q[i] <= 1'b0;
            else if (pl_we && pl_idx == IW'(i))    q[i] <= pl_val;
            else if (run_en)                       q[i] <= run_d[i];
        end
    end

    // R3: the preloaded register holds the preload value afterwards.
    a_r3_preload_wins: assert property (@(posedge clk) disable iff (!rst_n)
        pl_we |=> (q[$past(pl_idx)] == $past(pl_val)));

    // R4: with no load of either kind the registers hold.
    a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!pl_we && !run_en) |=> $stable(q));
endmodule

// File: rtl/plk_ctrl.sv
// Module: plk_ctrl - command decode, lock gating, response generation and
// erase sequencing. Accepts one command per cycle when idle; an erase stalls
// the handshake while it clears the configuration store one entry per cycle.
// Assumes CFG_DEPTH, SIG_BYTES and N_OUT each fit in the address field.
module plk_ctrl import plk_pkg::*; #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int CFG_DEPTH = 16,
    parameter int SIG_BYTES = 8,
    parameter int N_OUT     = 8,
    localparam int CFG_AW   = $clog2(CFG_DEPTH),
    localparam int SIG_AW   = $clog2(SIG_BYTES),
    localparam int IDX_W    = $clog2(N_OUT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_data,
    output logic              locked,
    input  logic [DATA_W-1:0] cfg_rdata,
    input  logic [DATA_W-1:0] sig_rdata,
    output logic              cfg_we,
    output logic [CFG_AW-1:0] cfg_addr,
    output logic [DATA_W-1:0] cfg_wdata,
    output logic              sig_we,
    output logic [SIG_AW-1:0] sig_addr,
    output logic [DATA_W-1:0] sig_wdata,
    output logic              pl_we,
    output logic [IDX_W-1:0]  pl_idx,
    output logic              pl_val
);
    localparam logic [ADDR_W:0]   CFG_LIM  = (ADDR_W+1)'(CFG_DEPTH);
    localparam logic [ADDR_W:0]   SIG_LIM  = (ADDR_W+1)'(SIG_BYTES);
    localparam logic [ADDR_W:0]   IDX_LIM  = (ADDR_W+1)'(N_OUT);
    localparam logic [CFG_AW-1:0] PTR_LAST = CFG_AW'(CFG_DEPTH - 1);

    plk_op_e           op;
    logic              busy;
    logic [CFG_AW-1:0] ptr;
    logic              accept;
    logic              refuse;
    logic              cfg_ok, sig_ok, idx_ok;
    logic [DATA_W-1:0] rd_mux;

    assign op        = plk_op_e'(cmd_op);
    assign cmd_ready = !busy;
    assign accept    = cmd_valid && !busy;
    assign cfg_ok    = {1'b0, cmd_addr} < CFG_LIM;
    assign sig_ok    = {1'b0, cmd_addr} < SIG_LIM;
    assign idx_ok    = {1'b0, cmd_addr} < IDX_LIM;

    // Refusal rule: lock gates preload and verify; range checks everywhere.
    always_comb begin
        unique case (op)
            OP_PRELOAD: refuse = locked || !idx_ok;
            OP_CFG_WR:  refuse = !cfg_ok;
            OP_CFG_VFY: refuse = locked || !cfg_ok;
            OP_SIG_WR,
            OP_SIG_RD:  refuse = !sig_ok;
            default:    refuse = 1'b0;
        endcase
    end

    // Read data selection for the response register.
    always_comb begin
        unique case (op)
            OP_CFG_VFY: rd_mux = cfg_rdata;
            OP_SIG_RD:  rd_mux = sig_rdata;
            default:    rd_mux = '0;
        endcase
    end

    // Store and register strobes; the erase sweep owns the config port while busy.
    assign cfg_we    = busy || (accept && op == OP_CFG_WR && !refuse);
    assign cfg_addr  = busy ? ptr : cmd_addr[CFG_AW-1:0];
    assign cfg_wdata = busy ? '0 : cmd_data;
    assign sig_we    = accept && op == OP_SIG_WR && !refuse;
    assign sig_addr  = cmd_addr[SIG_AW-1:0];
    assign sig_wdata = cmd_data;
    assign pl_we     = accept && op == OP_PRELOAD && !refuse;
    assign pl_idx    = cmd_addr[IDX_W-1:0];
    assign pl_val    = cmd_data[0];

    // Response, lock bit and erase sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            ptr       <= '0;
            locked    <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
            if (busy) begin
                if (ptr == PTR_LAST) begin
                    busy      <= 1'b0;
                    locked    <= 1'b0;
                    rsp_valid <= 1'b1;
                end else begin
                    ptr <= ptr + 1'b1;
                end
            end else if (cmd_valid) begin
                if (op == OP_ERASE) begin
                    busy <= 1'b1;
                    ptr  <= '0;
                end else if (op != OP_IDLE) begin
                    rsp_valid <= 1'b1;
                    rsp_err   <= refuse;
                    rsp_data  <= refuse ? '0 : rd_mux;
                    if (op == OP_LOCK) locked <= 1'b1;
                end
            end
        end
    end

    // R8: a verify accepted while locked is answered with an error next cycle.
    a_r8_locked_verify_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_CFG_VFY && locked) |=> (rsp_valid && rsp_err && rsp_data == '0));

    // R8: a preload accepted while locked is answered with an error next cycle.
    a_r8_locked_preload_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_PRELOAD && locked) |=> (rsp_valid && rsp_err));

    // R6: an in-range signature read never errors, locked or not.
    a_r6_sig_read_open: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_SIG_RD && sig_ok) |=> (rsp_valid && !rsp_err));

    // R10: the lock only falls at the end of an erase sweep.
    a_r10_lock_cleared_by_erase: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(busy));

    // R2: a response follows an accepted command or the last erase step.
    a_r2_rsp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(accept) || $past(busy)));
endmodule

// File: rtl/lock_preload_ctrl.sv
// Module: lock_preload_ctrl - top of the test/configuration access controller.
// Connects the command controller to the configuration store, the user
// signature store and the output register bank. Assumes one host driver.
module lock_preload_ctrl import plk_pkg::*; #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int CFG_DEPTH = 16,
    parameter int SIG_BYTES = 8,
    parameter int N_OUT     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_data,
    output logic              locked,
    input  logic              run_en,
    input  logic [N_OUT-1:0]  run_d,
    output logic [N_OUT-1:0]  reg_q
);
    localparam int CFG_AW = $clog2(CFG_DEPTH);
    localparam int SIG_AW = $clog2(SIG_BYTES);
    localparam int IDX_W  = $clog2(N_OUT);

    logic              cfg_we, sig_we, pl_we, pl_val;
    logic [CFG_AW-1:0] cfg_addr;
    logic [SIG_AW-1:0] sig_addr;
    logic [IDX_W-1:0]  pl_idx;
    logic [DATA_W-1:0] cfg_wdata, cfg_rdata, sig_wdata, sig_rdata;

    plk_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_DEPTH(CFG_DEPTH),
        .SIG_BYTES(SIG_BYTES), .N_OUT(N_OUT)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
        .locked(locked), .cfg_rdata(cfg_rdata), .sig_rdata(sig_rdata),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .sig_we(sig_we), .sig_addr(sig_addr), .sig_wdata(sig_wdata),
        .pl_we(pl_we), .pl_idx(pl_idx), .pl_val(pl_val)
    );

    plk_store #(.DEPTH(CFG_DEPTH), .WIDTH(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata)
    );

    plk_store #(.DEPTH(SIG_BYTES), .WIDTH(DATA_W)) u_sig (
        .clk(clk), .rst_n(rst_n), .we(sig_we), .addr(sig_addr),
        .wdata(sig_wdata), .rdata(sig_rdata)
    );

    plk_outreg #(.N(N_OUT)) u_out (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .run_d(run_d),
        .pl_we(pl_we), .pl_idx(pl_idx), .pl_val(pl_val), .q(reg_q)
    );

    // R7: a lock command accepted now shows on the lock output next cycle.
    a_r7_lock_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == OP_LOCK) |=> locked);
endmodule

// File: tb/sim_lock_preload_ctrl.sv
// Bench: behavioural reference model updated on every rising edge and compared
// with the design's outputs on every falling edge.
module sim_lock_preload_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [2:0] cmd_op = 3'd0;
    logic [3:0] cmd_addr = 4'd0;
    logic [7:0] cmd_data = 8'd0;
    logic       rsp_valid, rsp_err, locked;
    logic [7:0] rsp_data;
    logic       run_en = 1'b0;
    logic [7:0] run_d = 8'd0;
    logic [7:0] reg_q;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // reference model state
    logic [7:0] m_cfg [16];
    logic [7:0] m_sig [8];
    logic [7:0] m_q;
    logic       m_lock, m_busy, m_rv, m_re;
    logic [7:0] m_rd;
    int         m_ptr;

    always #2.5 clk = ~clk;

    lock_preload_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
        .locked(locked), .run_en(run_en), .run_d(run_d), .reg_q(reg_q)
    );

    // Reference model, written from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) m_cfg[i] = 8'd0;
            for (int i = 0; i < 8; i++)  m_sig[i] = 8'd0;
            m_q = 8'd0; m_lock = 0; m_busy = 0; m_rv = 0; m_re = 0; m_rd = 8'd0; m_ptr = 0;
        end else begin
            m_rv = 0; m_re = 0; m_rd = 8'd0;
            if (run_en) m_q = run_d;
            if (m_busy) begin
                m_cfg[m_ptr] = 8'd0;
                if (m_ptr == 15) begin m_busy = 0; m_lock = 0; m_rv = 1; end
                else m_ptr++;
            end else if (cmd_valid) begin
                case (cmd_op)
                    3'd1: begin m_rv = 1;
                        if (m_lock || cmd_addr >= 8) m_re = 1; else m_q[cmd_addr] = cmd_data[0]; end
                    3'd2: begin m_rv = 1; m_cfg[cmd_addr] = cmd_data; end
                    3'd3: begin m_rv = 1;
                        if (m_lock) m_re = 1; else m_rd = m_cfg[cmd_addr]; end
                    3'd4: begin m_rv = 1;
                        if (cmd_addr >= 8) m_re = 1; else m_sig[cmd_addr] = cmd_data; end
                    3'd5: begin m_rv = 1;
                        if (cmd_addr >= 8) m_re = 1; else m_rd = m_sig[cmd_addr]; end
                    3'd6: begin m_rv = 1; m_lock = 1; end
                    3'd7: begin m_busy = 1; m_ptr = 0; end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h at cycle %0d", cur_req, what, got, exp, cycles);
        end
    endtask

    // Compare every cycle away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk("cmd_ready", 32'(cmd_ready), 32'(!m_busy));
            chk("rsp_valid", 32'(rsp_valid), 32'(m_rv));
            if (m_rv) begin
                chk("rsp_err", 32'(rsp_err), 32'(m_re));
                chk("rsp_data", 32'(rsp_data), 32'(m_rd));
            end
            chk("locked", 32'(locked), 32'(m_lock));
            chk("reg_q", 32'(reg_q), 32'(m_q));
        end
    end

    // Issue one command; called at a falling edge, returns at a falling edge.
    task automatic send(input logic [2:0] op, input logic [3:0] a, input logic [7:0] d);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        // watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        cur_req = "R1";
        cmd_valid = 1'b1; cmd_op = 3'd6;          // held command must be ignored in reset
        repeat (3) @(negedge clk);
        chk("reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk("reset locked", 32'(locked), 32'd0);
        chk("reset reg_q", 32'(reg_q), 32'd0);
        chk("reset cmd_ready", 32'(cmd_ready), 32'd1);
        cmd_valid = 1'b0; cmd_op = 3'd0;
        rst_n = 1'b1;
        idle(1);
        send(3'd3, 4'd5, 8'h00);                  // R1: config reads zero after reset
        send(3'd5, 4'd2, 8'h00);                  // R1: signature reads zero after reset

        cur_req = "R2";
        send(3'd0, 4'd0, 8'hFF);
        send(3'd0, 4'd3, 8'h12);
        idle(2);

        cur_req = "R5";
        for (int i = 0; i < 16; i++) send(3'd2, 4'(i), 8'(8'h3C ^ (i * 37)));
        send(3'd2, 4'd15, 8'hA5);
        send(3'd2, 4'd0, 8'h5A);
        for (int i = 15; i >= 0; i--) send(3'd3, 4'(i), 8'h00);

        cur_req = "R6";
        for (int i = 0; i < 8; i++) send(3'd4, 4'(i), 8'(8'hC1 + i * 17));
        for (int i = 0; i < 8; i++) send(3'd5, 4'(i), 8'h00);

        cur_req = "R9";
        send(3'd4, 4'd9, 8'hEE);                  // out of range write refused
        send(3'd5, 4'd8, 8'h00);
        send(3'd5, 4'd12, 8'h00);
        send(3'd1, 4'd8, 8'h01);                  // preload index 8 refused
        send(3'd1, 4'd15, 8'h01);
        for (int i = 0; i < 8; i++) send(3'd5, 4'(i), 8'h00);

        cur_req = "R3";
        for (int i = 0; i < 8; i += 2) send(3'd1, 4'(i), 8'h01);
        send(3'd1, 4'd7, 8'hFF);
        send(3'd1, 4'd2, 8'hFE);                  // only bit 0 of data counts
        idle(1);

        cur_req = "R4";
        run_en = 1'b1; run_d = 8'h96;
        idle(2);
        run_d = 8'h0F;
        send(3'd1, 4'd1, 8'h00);                  // preload beats parallel load on bit 1
        run_d = 8'h00;
        send(3'd1, 4'd6, 8'h01);
        run_en = 1'b0; run_d = 8'hFF;
        idle(3);                                  // hold with run_en low

        cur_req = "R7";
        send(3'd6, 4'd0, 8'h00);
        cur_req = "R8";
        send(3'd3, 4'd4, 8'h00);                  // back-to-back after lock
        send(3'd1, 4'd3, 8'h01);
        send(3'd1, 4'd0, 8'h00);
        send(3'd2, 4'd4, 8'h77);                  // write still allowed
        send(3'd3, 4'd4, 8'h00);
        cur_req = "R6";
        send(3'd5, 4'd7, 8'h00);
        send(3'd4, 4'd3, 8'h42);
        send(3'd5, 4'd3, 8'h00);

        cur_req = "R10";
        send(3'd7, 4'd0, 8'h00);
        send(3'd3, 4'd4, 8'h00);                  // waits out the erase
        for (int i = 0; i < 16; i++) send(3'd3, 4'(i), 8'h00);
        for (int i = 0; i < 8; i++) send(3'd5, 4'(i), 8'h00);
        send(3'd1, 4'd5, 8'h01);                  // preload works again
        send(3'd7, 4'd0, 8'h00);                  // erase while unlocked
        idle(20);
        send(3'd3, 4'd0, 8'h00);
        idle(2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule